// File: doc/BRIEF.md
# On-Screen Display Dot Edge and Fast-Blank Stage

This block is the last stage of a four-row text overlay. It runs on the pixel clock. On every pixel it receives a three-bit vertical slice of the character glyph: the dot on the scanline above, on the current scanline and on the scanline below, all at the current column. It also receives a flag that says whether a display row is being drawn and an index that says which one. It holds a three-column window of these slices and decides three things for the centre column. It decides whether that column is a character dot, whether it is an edge dot, and whether the fast-blanking key toward the video mixer is asserted.

Each row can have a dark edge around its glyphs. A single shared mode bit makes that edge either a full outline (border) or a drop shadow toward the lower right. Each row also picks how the fast-blanking key behaves. It can key the whole row box, or only the glyph dots together with their edge dots. The block holds the row control registers. Their upper bit carries the control flag and their lower bits carry position values that it passes on to the position matcher.

The upstream fetcher inserts zero slices between character cells where no glyph exists. Column neighbours are simply the adjacent samples in the stream.

Top module: `osd_edge_blank`

## Requirements
- R1: After reset, every control register reads zero and `dot_o`, `rim_o` and `fblank_o` are low.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`. Values 0 to ROWS-1 select that row's vertical register, whose bit 7 is the row's blank-mode flag. Value ROWS selects the horizontal register, whose bit 7 is the shadow select. Value ROWS+1 selects the edge-enable register, in which bit i enables row i. The low 7 bits of the vertical and horizontal registers appear on `vpos_o` (row i at bits 7i+6..7i) and on `hpos_o`.
- R3: `dot_col` bit 0 is the dot above, bit 1 the current dot and bit 2 the dot below. The slice sampled at clock edge k is the centre column for the outputs that follow edge k+1. `dot_o` equals its bit 1 when the row was active at edge k.
- R4: In border mode (shadow select 0), `rim_o` is high for a non-glyph centre dot if any of its eight neighbours is a glyph dot. The neighbours are all three bits of the left and right slices and bits 0 and 2 of the centre slice.
- R5: In shadow mode (shadow select 1), `rim_o` is high for a non-glyph centre dot only if bit 0 of the left slice (the up-left neighbour) is set.
- R6: If the active row's edge-enable bit is clear, `rim_o` stays low, whatever the shadow select is.
- R7: `dot_o` and `rim_o` are never high together. A glyph dot wins.
- R8: If the active row's blank-mode flag is 0, `fblank_o` is high on every dot of that row.
- R9: If the active row's blank-mode flag is 1, `fblank_o` equals `dot_o` OR `rim_o`.
- R10: When no row is active for the centre slice, all three dot outputs are low.
- R11: Edge enables are independent per row. The row index that arrives with the centre slice picks which enable, and which blank-mode flag, apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (rows, horizontal, edge enable) |
| wr_data | input | 8 | Register write data |
| row_act | input | 1 | A display row is being drawn at this pixel |
| row_idx | input | 2 | Index of the active row |
| dot_col | input | 3 | Glyph slice: {below, current, above} |
| dot_o | output | 1 | Glyph dot |
| rim_o | output | 1 | Border or shadow dot |
| fblank_o | output | 1 | Fast-blanking key |
| vpos_o | output | 28 | Vertical position fields, 7 bits per row |
| hpos_o | output | 7 | Horizontal position field |

## Verification
The embedded properties check several rules on every cycle. Glyph and edge dots must not overlap. The outputs must be quiet when no row is active. Edges must be absent for a disabled row. Box-mode blanking must be continuous. Character-mode blanking must equal the dot union. Shadow edges must appear only where the up-left neighbour is set. Whether the correct neighbours form the border, whether the row index selects the right register, and whether writes land in the right field can only be shown by the bench. It compares every output against a behavioural neighbour model under random glyphs, both edge modes, mixed blank flags and idle gaps.

// File: rtl/osd_edge_blank.sv
module osd_edge_blank #(
  parameter int ROWS = 4,
  parameter int REGW = 8,
  localparam int POSW = REGW - 1,
  localparam int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SELW = $clog2(ROWS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SELW-1:0]      wr_sel,
  input  logic [REGW-1:0]      wr_data,
  input  logic                 row_act,
  input  logic [IDXW-1:0]      row_idx,
  input  logic [2:0]           dot_col,
  output logic                 dot_o,
  output logic                 rim_o,
  output logic                 fblank_o,
  output logic [ROWS*POSW-1:0] vpos_o,
  output logic [POSW-1:0]      hpos_o
);
  localparam logic [SELW-1:0] SEL_H = SELW'(ROWS);
  localparam logic [SELW-1:0] SEL_E = SELW'(ROWS + 1);

  logic [REGW-1:0] vreg [ROWS];
  logic [REGW-1:0] hreg;
  logic [ROWS-1:0] een;
  logic [2:0]      lft, mid;
  logic            act_m;
  logic [IDXW-1:0] idx_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) vreg[i] <= '0;
      hreg <= '0;
      een  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_H) hreg <= wr_data;
      else if (wr_sel == SEL_E) een <= wr_data[ROWS-1:0];
      else if (int'(wr_sel) < ROWS) vreg[wr_sel[IDXW-1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_pos
    assign vpos_o[g*POSW +: POSW] = vreg[g][POSW-1:0];
  end
  assign hpos_o = hreg[POSW-1:0];

  wire shadow = hreg[REGW-1];
  wire row_en = een[idx_m];
  wire fb_chr = vreg[idx_m][REGW-1];
  wire ctr    = mid[1];
  wire ring   = (|lft) | (|dot_col) | mid[0] | mid[2];
  wire near   = shadow ? lft[0] : ring;
  wire char_n = act_m & ctr;
  wire rim_n  = act_m & row_en & ~ctr & near;
  wire fb_n   = act_m & (~fb_chr | char_n | rim_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lft      <= '0;
      mid      <= '0;
      act_m    <= 1'b0;
      idx_m    <= '0;
      dot_o    <= 1'b0;
      rim_o    <= 1'b0;
      fblank_o <= 1'b0;
    end else begin
      lft      <= mid;
      mid      <= dot_col;
      act_m    <= row_act;
      idx_m    <= row_idx;
      dot_o    <= char_n;
      rim_o    <= rim_n;
      fblank_o <= fb_n;
    end
  end

  AST_RIM_DOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dot_o && rim_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_m |=> !(dot_o || rim_o || fblank_o)); // R10
  AST_RIM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m && !een[idx_m]) |=> !rim_o); // R6
  AST_BOX_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m && !vreg[idx_m][REGW-1]) |=> fblank_o); // R8
  AST_BLANK_UNION: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m && vreg[idx_m][REGW-1]) |=> (fblank_o == (dot_o || rim_o))); // R9
  AST_SHADOW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m && hreg[REGW-1] && !lft[0]) |=> !rim_o); // R5
endmodule

// File: tb/osd_edge_blank_bench.sv
`timescale 1ns/1ps
module osd_edge_blank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic row_act = 1'b0;
  logic [1:0] row_idx = '0;
  logic [2:0] dot_col = '0;
  logic dot_o, rim_o, fblank_o;
  logic [27:0] vpos_o;
  logic [6:0] hpos_o;

  always #2.5 clk = ~clk;

  osd_edge_blank u_osd_edge_blank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .row_act(row_act), .row_idx(row_idx), .dot_col(dot_col),
    .dot_o(dot_o), .rim_o(rim_o), .fblank_o(fblank_o), .vpos_o(vpos_o), .hpos_o(hpos_o));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct { bit [2:0] c; bit a; int i; } smp_t;
  smp_t hist[$];
  bit [7:0] m_v [4];
  bit [7:0] m_h;
  bit [3:0] m_en;
  bit e_dot, e_rim, e_fb, e_act, e_en, e_sh, e_fc;
  int e_idx;
  bit cmp_on = 0;
  int rim_seen [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      foreach (m_v[k]) m_v[k] = 0;
      m_h = 0; m_en = 0;
      e_dot = 0; e_rim = 0; e_fb = 0; e_act = 0; e_idx = 0; e_en = 0; e_sh = 0; e_fc = 0;
    end else begin
      smp_t z, l, m, r;
      int hits;
      z = '{c: 3'b000, a: 1'b0, i: 0};
      l = hist.size() >= 2 ? hist[hist.size()-2] : z;
      m = hist.size() >= 1 ? hist[hist.size()-1] : z;
      r = '{c: dot_col, a: row_act, i: int'(row_idx)};
      hits = 0;
      for (int dx = -1; dx <= 1; dx++)
        for (int dy = 0; dy < 3; dy++) begin
          smp_t s;
          if (dx == 0 && dy == 1) continue;
          s = (dx < 0) ? l : (dx > 0) ? r : m;
          if (s.c[dy]) hits++;
        end
      e_act = m.a; e_idx = m.i;
      e_en = m_en[m.i]; e_sh = m_h[7]; e_fc = m_v[m.i][7];
      e_dot = m.a && m.c[1];
      e_rim = m.a && e_en && !m.c[1] && (e_sh ? l.c[0] : (hits > 0));
      e_fb = m.a && (!e_fc || e_dot || e_rim);
      if (wr_en) begin
        if (wr_sel == 3'd4) m_h = wr_data;
        else if (wr_sel == 3'd5) m_en = wr_data[3:0];
        else if (wr_sel < 3'd4) m_v[wr_sel] = wr_data;
      end
      hist.push_back(r);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  always @(negedge clk) if (cmp_on && !done) begin
    chk("R7", int'(dot_o && rim_o), 0);
    chk(e_act ? "R3" : "R10", dot_o, e_dot);
    chk(!e_act ? "R10" : !e_en ? "R6" : e_sh ? "R5" : "R4", rim_o, e_rim);
    chk(!e_act ? "R10" : e_fc ? "R9" : "R8", fblank_o, e_fb);
    if (rim_o) rim_seen[e_idx]++;
  end

  task automatic wr(int sel, int data);
    @(negedge clk); #1;
    wr_en = 1; wr_sel = 3'(sel); wr_data = 8'(data);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run(int n, int fixed_row, int act_pct);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      row_act = ($urandom % 100) < act_pct;
      row_idx = fixed_row >= 0 ? 2'(fixed_row) : 2'($urandom % 4);
      dot_col = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
    end
    @(negedge clk); #1; row_act = 0; dot_col = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", dot_o, 0); chk("R1", rim_o, 0); chk("R1", fblank_o, 0);
    chk("R1", int'(vpos_o), 0); chk("R1", hpos_o, 0);
    #1 rst_n = 1;
    cmp_on = 1;
    // R2: register placement
    wr(0, 8'h85); wr(1, 8'h12); wr(2, 8'hC0); wr(3, 8'h7F); wr(4, 8'hFF); wr(6, 8'hFF);
    @(negedge clk);
    chk("R2", vpos_o[6:0], 7'h05); chk("R2", vpos_o[13:7], 7'h12);
    chk("R2", vpos_o[20:14], 7'h40); chk("R2", vpos_o[27:21], 7'h7F);
    chk("R2", hpos_o, 7'h7F);
    // border mode, all rows edged, box blanking
    wr(4, 8'h00); wr(5, 8'h0F);
    for (int r = 0; r < 4; r++) wr(r, 8'h00);
    run(500, -1, 90);
    // shadow mode
    wr(4, 8'h80);
    run(500, -1, 90);
    // character-only blanking on rows 1 and 3, both edge modes
    wr(1, 8'h80); wr(3, 8'h80);
    run(400, -1, 85);
    wr(4, 8'h00);
    run(400, -1, 85);
    // R11 / R6: only row 2 edged, shadow select set must not matter for row 1
    wr(5, 8'h04); wr(4, 8'h80);
    foreach (rim_seen[k]) rim_seen[k] = 0;
    run(300, 1, 100);
    run(300, 2, 100);
    chk("R11", rim_seen[1], 0);
    chk("R11", int'(rim_seen[2] > 0), 1);
    wr(4, 8'h00);
    run(300, 1, 100);
    chk("R6", rim_seen[1], 0);
    // R10: idle with glyph data present
    run(300, -1, 0);
    run(200, -1, 50);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule